// File: doc/BRIEF.md
# Addressed Three-Wire Serial Register Port

This block is a serial slave with three host wires: chip enable, clock and data in. It drives one data-out wire with a separate enable, so the pad can be built open-drain. The host first shifts an 8-bit address while chip enable is low. It then raises chip enable. The address picks the transaction: one of two 16-bit control writes, or a streaming read from the decoded-block buffer.

A control write shifts data bits in and applies them to the live control outputs only when chip enable falls. A read turns each buffer entry into a 32-bit frame and shifts it out, most significant bit first. Frames follow one another for as long as chip enable stays high. The buffer entry is released when the 31st clock of its frame arrives. A read cut short before that point returns the same entry on the next read.

All three host wires are brought into the block clock domain and sampled there. Input data is taken on serial clock rising edges. Output bits advance on falling edges. Because of this, a host may idle the clock either high or low with no configuration.

Top module: `ser3w_port`

## Requirements
- R1: After reset, group one reads 0x0902 and group two reads 0x0034, packed as in R3. The data-out enable is low and no buffer entry is released.
- R2: The address is the last 8 bits shifted while chip enable is low, least significant bit first.
  - 0x6A selects group one, 0x6B selects group two and 0x6C selects read.
  - Any other address changes no control output and never enables data out.
- R3: A write stores the first data bit in bit 0 of the group.
  - Group one: [3:0] cfg_fwd_prot, [4] cfg_det_mode, [5] cfg_sync_hold, [6] cfg_keep_unsync, [11:7] cfg_ec, [13:12] cfg_tune. Bits [15:14] are dropped.
  - Group two: [0] cfg_osc_sel, [2:1] cfg_phase, [3] cfg_rbds_en, [6:4] cfg_pin_mode, [10:7] cfg_test. Bits [15:11] are dropped.
  - A write with any bit count other than 16 is ignored.
- R4: sync_restart pulses for exactly one clock when a group-one write changes cfg_sync_hold from 1 to 0. It stays low for any other write.
- R5: A read frame is laid out as follows, and bit 31 is sent first:
  - [31:28] = 1010; [27] sync flag; [26] ari flag; [25] offset-detected flag; [24:22] offset code.
  - [21:19] error field; [18] more; [17:16] fill; [15:0] data.
  - Data out is enabled only inside a read window.
- R6: The error field is 110 when the entry's error count is 6 or 7. It is also 110 when the count exceeds the limit held in cfg_ec[2:0]. Otherwise the field equals the count.
- R7: more is 1 when the buffer holds at least two entries as the frame is loaded.
  - fill is 0 for 1 to 7 entries, 1 for 8 to 15 entries, 2 for 16 to 23 entries and 3 for 24 entries.
- R8: A frame loaded while the buffer is empty is all zeros and releases no entry.
- R9: One read window streams any number of consecutive frames.
  - Each entry is released on the 31st clock of its frame.
  - A window that ends before that clock leaves the entry in place.
- R10: Writes and reads give identical results whether the serial clock idles high or low.
- R11: The control outputs change only in the clock after chip enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_ce | input | 1 | Serial chip enable |
| ser_cl | input | 1 | Serial clock |
| ser_di | input | 1 | Serial data in |
| ser_do | output | 1 | Serial data out bit |
| ser_do_oe | output | 1 | Data-out enable (read window) |
| buf_level | input | LVL_W | Entries held in the block buffer |
| head_data | input | DATA_W | Data word of oldest entry |
| head_offset | input | 3 | Offset code of oldest entry |
| head_errs | input | 3 | Raw error count of oldest entry |
| head_sync | input | 1 | Lock state stored with oldest entry |
| head_ari | input | 1 | Side-channel flag of oldest entry |
| head_det | input | 1 | Offset-detected flag of oldest entry |
| head_pop | output | 1 | Release oldest entry |
| cfg_fwd_prot | output | 4 | Loss-of-lock rule |
| cfg_det_mode | output | 1 | Lock acquisition rule |
| cfg_sync_hold | output | 1 | Lock search held in reset |
| sync_restart | output | 1 | One-clock restart pulse |
| cfg_keep_unsync | output | 1 | Store unlocked blocks |
| cfg_ec | output | 5 | Correction limit and decision mode |
| cfg_tune | output | 2 | Detector tuning |
| cfg_osc_sel | output | 1 | Oscillator select |
| cfg_phase | output | 2 | Demodulator phase control |
| cfg_rbds_en | output | 1 | Extra offset word enable |
| cfg_pin_mode | output | 3 | Status pin mode |
| cfg_test | output | 4 | Test selection |

## Verification
The bench builds the block with its default parameters:

| Parameter | Value |
|---|---|
| BUF_DEPTH | 24 |
| SYNC_STAGES | 2 |
| DATA_W | 16 |

A depth of 24 lets a model buffer be filled completely. One read window can then walk the fill code through all four values and end on an empty all-zero frame. Two synchronizer stages fix the delay from a serial clock edge to the data-out update, and this delay sits well inside the bench's eight-cycle half period. The bench covers both clock idle levels, cut-off reads before and at the release clock, and every error count against random correction limits.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;

   typedef enum logic [1:0] {PM_IDLE, PM_WR1, PM_WR2, PM_READ} port_mode_e;

   localparam logic [7:0] ADDR_WR1  = 8'h6A;
   localparam logic [7:0] ADDR_WR2  = 8'h6B;
   localparam logic [7:0] ADDR_READ = 8'h6C;

   localparam int REG_W    = 16;
   localparam int HOLD_BIT = 5;
   localparam int FLAG_W   = 12;

   localparam logic [REG_W-1:0] WR1_RST  = 16'h0902;
   localparam logic [REG_W-1:0] WR1_MASK = 16'h3FFF;
   localparam logic [REG_W-1:0] WR2_RST  = 16'h0034;
   localparam logic [REG_W-1:0] WR2_MASK = 16'h07FF;

   localparam logic [3:0] PREAMBLE = 4'b1010;

   function automatic logic [2:0] clamp_err(input logic [2:0] cnt, input logic [2:0] lim);
      return (cnt >= 3'd6 || cnt > lim) ? 3'd6 : cnt;
   endfunction

endpackage

// File: rtl/ser3w_sync.sv
module ser3w_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   initial assert (STAGES >= 1 && WIDTH >= 1) else $error("ser3w_sync: bad parameters");

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      if (STAGES == 1) begin : g_one
         logic stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= 1'b0;
            else        stage_q <= d_in[b];
         end
         assign d_out[b] = stage_q;
      end else begin : g_many
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_in[b]};
         end
         assign d_out[b] = chain_q[STAGES-1];
      end
   end

endmodule

// File: rtl/ser3w_front.sv
module ser3w_front
   import ser3w_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ce_s,
   input  logic       cl_s,
   input  logic       di_s,
   output logic       cl_rise,
   output logic       cl_fall,
   output logic       ce_rise,
   output logic       ce_fall,
   output logic       start_read,
   output port_mode_e mode
);

   logic       ce_d, cl_d;
   logic [7:0] addr_q;
   port_mode_e mode_dec;

   assign cl_rise = cl_s & ~cl_d;
   assign cl_fall = ~cl_s & cl_d;
   assign ce_rise = ce_s & ~ce_d;
   assign ce_fall = ~ce_s & ce_d;

   always_comb begin
      case (addr_q)
         ADDR_WR1:  mode_dec = PM_WR1;
         ADDR_WR2:  mode_dec = PM_WR2;
         ADDR_READ: mode_dec = PM_READ;
         default:   mode_dec = PM_IDLE;
      endcase
   end

   assign start_read = ce_rise && (mode_dec == PM_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_d   <= 1'b0;
         cl_d   <= 1'b0;
         addr_q <= '0;
         mode   <= PM_IDLE;
      end else begin
         ce_d <= ce_s;
         cl_d <= cl_s;
         if (cl_rise && !ce_s) addr_q <= {di_s, addr_q[7:1]};
         if (ce_rise)      mode <= mode_dec;
         else if (ce_fall) mode <= PM_IDLE;
      end
   end

   AST_MODE_IDLE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_s && !ce_fall) |-> (mode == PM_IDLE)); // R2

endmodule

// File: rtl/ser3w_wregs.sv
module ser3w_wregs
   import ser3w_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cl_rise,
   input  logic             ce_s,
   input  logic             ce_fall,
   input  logic             di_s,
   input  port_mode_e       mode,
   output logic [REG_W-1:0] grp1,
   output logic [REG_W-1:0] grp2,
   output logic             restart
);

   localparam int CNT_W = $clog2(REG_W) + 2;
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(REG_W);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;

   logic [REG_W-1:0] sh_q;
   logic [CNT_W-1:0] cnt_q;
   logic [REG_W-1:0] grp_q [2];
   logic             wr_mode, take;

   assign wr_mode = (mode == PM_WR1) || (mode == PM_WR2);
   assign take    = ce_fall && (cnt_q == CNT_FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (ce_fall) begin
         cnt_q <= '0;
      end else if (cl_rise && ce_s && wr_mode) begin
         sh_q <= {di_s, sh_q[REG_W-1:1]};
         if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
   end

   for (genvar g = 0; g < 2; g++) begin : g_grp
      localparam logic [REG_W-1:0] RSTV  = (g == 0) ? WR1_RST : WR2_RST;
      localparam logic [REG_W-1:0] MASKV = (g == 0) ? WR1_MASK : WR2_MASK;
      localparam port_mode_e       SEL   = (g == 0) ? PM_WR1 : PM_WR2;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    grp_q[g] <= RSTV;
         else if (take && mode == SEL)  grp_q[g] <= sh_q & MASKV;
      end

      AST_CFG_WAITS_CE: assert property (@(posedge clk) disable iff (!rst_n)
         !ce_fall |=> $stable(grp_q[g])); // R11
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) restart <= 1'b0;
      else        restart <= take && (mode == PM_WR1) && grp_q[0][HOLD_BIT] && !sh_q[HOLD_BIT];
   end

   assign grp1 = grp_q[0];
   assign grp2 = grp_q[1];

   AST_RESTART_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> $fell(grp_q[0][HOLD_BIT])); // R4

endmodule

// File: rtl/ser3w_reader.sv
module ser3w_reader
   import ser3w_pkg::*;
#(
   parameter int BUF_DEPTH = 24,
   parameter int DATA_W    = 16,
   parameter int LVL_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              ce_s,
   input  logic              ce_fall,
   input  logic              cl_rise,
   input  logic              cl_fall,
   input  logic [2:0]        limit,
   input  logic [LVL_W-1:0]  level,
   input  logic [DATA_W-1:0] h_data,
   input  logic [2:0]        h_offset,
   input  logic [2:0]        h_errs,
   input  logic              h_sync,
   input  logic              h_ari,
   input  logic              h_det,
   output logic              do_bit,
   output logic              do_oe,
   output logic              pop
);

   localparam int FRAME_W = 4 + FLAG_W + DATA_W;
   localparam int IDX_W   = $clog2(FRAME_W);
   localparam logic [IDX_W-1:0] LAST   = IDX_W'(FRAME_W - 1);
   localparam logic [IDX_W-1:0] PENULT = IDX_W'(FRAME_W - 2);
   localparam logic [LVL_W-1:0] LVL_TWO  = LVL_W'(2);
   localparam logic [LVL_W-1:0] LVL_TH1  = LVL_W'(BUF_DEPTH / 3);
   localparam logic [LVL_W-1:0] LVL_TH2  = LVL_W'((2 * BUF_DEPTH) / 3);
   localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(BUF_DEPTH);

   initial assert (BUF_DEPTH >= 3 && DATA_W >= 1) else $error("ser3w_reader: bad parameters");

   logic [FRAME_W-1:0] frame_q, frame_nxt;
   logic [IDX_W-1:0]   idx_q, rcnt_q;
   logic               has_q, seen_q, active_q;
   logic [1:0]         fill;
   logic               more, avail;

   assign avail = (level != '0);
   assign more  = (level >= LVL_TWO);

   always_comb begin
      if (level >= LVL_FULL)     fill = 2'd3;
      else if (level >= LVL_TH2) fill = 2'd2;
      else if (level >= LVL_TH1) fill = 2'd1;
      else                       fill = 2'd0;
   end

   always_comb begin
      if (avail)
         frame_nxt = {PREAMBLE, h_sync, h_ari, h_det, h_offset,
                      clamp_err(h_errs, limit), more, fill, h_data};
      else
         frame_nxt = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q  <= '0;
         idx_q    <= '0;
         rcnt_q   <= '0;
         has_q    <= 1'b0;
         seen_q   <= 1'b0;
         active_q <= 1'b0;
      end else if (start) begin
         active_q <= 1'b1;
         frame_q  <= frame_nxt;
         has_q    <= avail;
         idx_q    <= '0;
         rcnt_q   <= '0;
         seen_q   <= 1'b0;
      end else if (ce_fall) begin
         active_q <= 1'b0;
      end else if (active_q) begin
         if (cl_rise) begin
            rcnt_q <= (rcnt_q == LAST) ? '0 : rcnt_q + 1'b1;
            seen_q <= 1'b1;
         end
         if (cl_fall) begin
            idx_q <= rcnt_q;
            if (rcnt_q == '0 && seen_q) begin
               frame_q <= frame_nxt;
               has_q   <= avail;
            end
         end
      end
   end

   assign pop    = active_q && cl_rise && has_q && (rcnt_q == PENULT);
   assign do_bit = frame_q[LAST - idx_q];
   assign do_oe  = active_q;

   AST_POP_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (level != '0)); // R8
   AST_SINGLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> !pop); // R9
   AST_OE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_s |=> !do_oe); // R5
   AST_FRAME_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (frame_q[FRAME_W-1 -: 4] == PREAMBLE || frame_q == '0)); // R5

endmodule

// File: rtl/ser3w_port.sv
module ser3w_port
   import ser3w_pkg::*;
#(
   parameter int  SYNC_STAGES = 2,
   parameter int  BUF_DEPTH   = 24,
   parameter int  DATA_W      = 16,
   localparam int LVL_W       = $clog2(BUF_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_ce,
   input  logic              ser_cl,
   input  logic              ser_di,
   output logic              ser_do,
   output logic              ser_do_oe,
   input  logic [LVL_W-1:0]  buf_level,
   input  logic [DATA_W-1:0] head_data,
   input  logic [2:0]        head_offset,
   input  logic [2:0]        head_errs,
   input  logic              head_sync,
   input  logic              head_ari,
   input  logic              head_det,
   output logic              head_pop,
   output logic [3:0]        cfg_fwd_prot,
   output logic              cfg_det_mode,
   output logic              cfg_sync_hold,
   output logic              sync_restart,
   output logic              cfg_keep_unsync,
   output logic [4:0]        cfg_ec,
   output logic [1:0]        cfg_tune,
   output logic              cfg_osc_sel,
   output logic [1:0]        cfg_phase,
   output logic              cfg_rbds_en,
   output logic [2:0]        cfg_pin_mode,
   output logic [3:0]        cfg_test
);

   logic       ce_s, cl_s, di_s;
   logic       cl_rise, cl_fall, ce_rise, ce_fall, start_read;
   port_mode_e mode;
   logic [REG_W-1:0] grp1, grp2;
   logic unused_bits;

   ser3w_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({ser_ce, ser_cl, ser_di}),
      .d_out ({ce_s, cl_s, di_s})
   );

   ser3w_front u_front (
      .clk        (clk),
      .rst_n      (rst_n),
      .ce_s       (ce_s),
      .cl_s       (cl_s),
      .di_s       (di_s),
      .cl_rise    (cl_rise),
      .cl_fall    (cl_fall),
      .ce_rise    (ce_rise),
      .ce_fall    (ce_fall),
      .start_read (start_read),
      .mode       (mode)
   );

   ser3w_wregs u_wregs (
      .clk     (clk),
      .rst_n   (rst_n),
      .cl_rise (cl_rise),
      .ce_s    (ce_s),
      .ce_fall (ce_fall),
      .di_s    (di_s),
      .mode    (mode),
      .grp1    (grp1),
      .grp2    (grp2),
      .restart (sync_restart)
   );

   ser3w_reader #(.BUF_DEPTH(BUF_DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_reader (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start_read),
      .ce_s     (ce_s),
      .ce_fall  (ce_fall),
      .cl_rise  (cl_rise),
      .cl_fall  (cl_fall),
      .limit    (grp1[9:7]),
      .level    (buf_level),
      .h_data   (head_data),
      .h_offset (head_offset),
      .h_errs   (head_errs),
      .h_sync   (head_sync),
      .h_ari    (head_ari),
      .h_det    (head_det),
      .do_bit   (ser_do),
      .do_oe    (ser_do_oe),
      .pop      (head_pop)
   );

   assign cfg_fwd_prot    = grp1[3:0];
   assign cfg_det_mode    = grp1[4];
   assign cfg_sync_hold   = grp1[HOLD_BIT];
   assign cfg_keep_unsync = grp1[6];
   assign cfg_ec          = grp1[11:7];
   assign cfg_tune        = grp1[13:12];
   assign cfg_osc_sel     = grp2[0];
   assign cfg_phase       = grp2[2:1];
   assign cfg_rbds_en     = grp2[3];
   assign cfg_pin_mode    = grp2[6:4];
   assign cfg_test        = grp2[10:7];
   assign unused_bits     = ^{grp1[15:14], grp2[15:11], ce_rise};

endmodule

// File: tb/ser3w_port_bench.sv
module ser3w_port_bench;

   localparam int H = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic ser_ce = 1'b0, ser_cl = 1'b0, ser_di = 1'b0;
   logic ser_do, ser_do_oe, head_pop, sync_restart;
   logic [3:0] cfg_fwd_prot, cfg_test;
   logic cfg_det_mode, cfg_sync_hold, cfg_keep_unsync, cfg_osc_sel, cfg_rbds_en;
   logic [4:0] cfg_ec;
   logic [1:0] cfg_tune, cfg_phase;
   logic [2:0] cfg_pin_mode;

   logic [15:0] m_data [64];
   logic [2:0]  m_off [64];
   logic [2:0]  m_err [64];
   logic        m_sync [64];
   logic        m_ari [64];
   logic        m_det [64];
   logic [5:0]  wr_p = 6'd0;
   logic [5:0]  rd_p;
   logic [5:0]  cnt6;
   logic [4:0]  buf_level;
   assign cnt6      = wr_p - rd_p;
   assign buf_level = cnt6[4:0];

   int pop_cnt, rs_cnt, oe_cnt;
   always @(posedge clk) begin
      if (!rst_n) begin
         rd_p <= 6'd0; pop_cnt <= 0; rs_cnt <= 0; oe_cnt <= 0;
      end else begin
         if (head_pop) begin rd_p <= rd_p + 6'd1; pop_cnt <= pop_cnt + 1; end
         if (sync_restart) rs_cnt <= rs_cnt + 1;
         if (ser_do_oe) oe_cnt <= oe_cnt + 1;
      end
   end

   ser3w_port u_ser3w_port (
      .clk(clk), .rst_n(rst_n), .ser_ce(ser_ce), .ser_cl(ser_cl), .ser_di(ser_di),
      .ser_do(ser_do), .ser_do_oe(ser_do_oe), .buf_level(buf_level),
      .head_data(m_data[rd_p]), .head_offset(m_off[rd_p]), .head_errs(m_err[rd_p]),
      .head_sync(m_sync[rd_p]), .head_ari(m_ari[rd_p]), .head_det(m_det[rd_p]),
      .head_pop(head_pop), .cfg_fwd_prot(cfg_fwd_prot), .cfg_det_mode(cfg_det_mode),
      .cfg_sync_hold(cfg_sync_hold), .sync_restart(sync_restart),
      .cfg_keep_unsync(cfg_keep_unsync), .cfg_ec(cfg_ec), .cfg_tune(cfg_tune),
      .cfg_osc_sel(cfg_osc_sel), .cfg_phase(cfg_phase), .cfg_rbds_en(cfg_rbds_en),
      .cfg_pin_mode(cfg_pin_mode), .cfg_test(cfg_test)
   );

   logic [15:0] g1_now, g2_now;
   assign g1_now = {2'b00, cfg_tune, cfg_ec, cfg_keep_unsync, cfg_sync_hold, cfg_det_mode, cfg_fwd_prot};
   assign g2_now = {5'b00000, cfg_test, cfg_pin_mode, cfg_rbds_en, cfg_phase, cfg_osc_sel};

   int checks = 0, errors = 0;
   logic idle_hi = 1'b0;
   logic [15:0] exp_g1 = 16'h0902, exp_g2 = 16'h0034;

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_pulse(input logic d, output logic s);
      ser_di = d;
      if (idle_hi) begin
         ser_cl = 1'b0; wait_cyc(H); s = ser_do; ser_cl = 1'b1; wait_cyc(H);
      end else begin
         wait_cyc(H); s = ser_do; ser_cl = 1'b1; wait_cyc(H); ser_cl = 1'b0;
      end
   endtask

   task automatic start_tx(input logic [7:0] addr);
      logic s;
      ser_ce = 1'b0; ser_cl = idle_hi; wait_cyc(H);
      for (int i = 0; i < 8; i++) bit_pulse(addr[i], s);
      wait_cyc(H); ser_ce = 1'b1; wait_cyc(H);
   endtask

   task automatic end_tx();
      wait_cyc(H); ser_ce = 1'b0; wait_cyc(2 * H);
   endtask

   task automatic write_grp(input logic [7:0] addr, input logic [15:0] val, input int nbits);
      logic s;
      start_tx(addr);
      for (int i = 0; i < nbits; i++) bit_pulse(val[i % 16], s);
      end_tx();
   endtask

   function automatic logic [31:0] exp_frame();
      logic [2:0] lim, ec;
      logic [1:0] fill;
      int c;
      c = int'(cnt6);
      if (c == 0) return 32'h0;
      lim  = exp_g1[9:7];
      ec   = (m_err[rd_p] >= 3'd6 || m_err[rd_p] > lim) ? 3'd6 : m_err[rd_p];
      fill = (c >= 24) ? 2'd3 : (c >= 16) ? 2'd2 : (c >= 8) ? 2'd1 : 2'd0;
      return {4'b1010, m_sync[rd_p], m_ari[rd_p], m_det[rd_p], m_off[rd_p], ec,
              (c >= 2), fill, m_data[rd_p]};
   endfunction

   task automatic read_bits(input int nbits, input string tag);
      logic s;
      logic [31:0] got, exp;
      got = '0; exp = '0;
      start_tx(8'h6C);
      for (int b = 0; b < nbits; b++) begin
         if (b % 32 == 0) exp = exp_frame();
         bit_pulse(1'b0, s);
         got[31 - (b % 32)] = s;
         if (b % 32 == 31) chk(tag, got, exp);
      end
      end_tx();
   endtask

   task automatic push_rand(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         m_data[wr_p] = 16'($urandom);
         m_off[wr_p]  = 3'($urandom);
         m_err[wr_p]  = 3'(i % 8);
         m_sync[wr_p] = 1'($urandom);
         m_ari[wr_p]  = 1'($urandom);
         m_det[wr_p]  = 1'($urandom);
         wr_p = wr_p + 6'd1;
      end
   endtask

   task automatic set_g1(input logic [15:0] v);
      write_grp(8'h6A, v, 16);
      exp_g1 = v & 16'h3FFF;
   endtask

   initial begin
      logic [15:0] v;
      int p0, o0;
      void'($urandom(32'd7321));
      wait_cyc(10);
      rst_n = 1'b1;
      wait_cyc(5);
      chk("R1 group one reset", 32'(g1_now), 32'h0902);
      chk("R1 group two reset", 32'(g2_now), 32'h0034);
      chk("R1 no enable, no release", {30'd0, ser_do_oe, 1'b0}, {31'd0, 1'b0} | 32'(pop_cnt));

      idle_hi = 1'b0;
      v = 16'($urandom); v[5] = 1'b0;
      set_g1(v);
      chk("R2 R3 group one write idle low", 32'(g1_now), 32'(exp_g1));
      idle_hi = 1'b1;
      v = 16'($urandom);
      write_grp(8'h6B, v, 16); exp_g2 = v & 16'h07FF;
      chk("R10 R3 group two write idle high", 32'(g2_now), 32'(exp_g2));
      v = 16'($urandom); v[5] = 1'b0;
      set_g1(v);
      chk("R10 group one write idle high", 32'(g1_now), 32'(exp_g1));

      idle_hi = 1'b0;
      begin
         logic s;
         v = 16'($urandom); v[5] = 1'b0;
         start_tx(8'h6A);
         for (int i = 0; i < 16; i++) bit_pulse(v[i], s);
         wait_cyc(H);
         chk("R11 outputs held before chip enable falls", 32'(g1_now), 32'(exp_g1));
         end_tx();
         exp_g1 = v & 16'h3FFF;
         chk("R11 outputs applied after chip enable falls", 32'(g1_now), 32'(exp_g1));
      end

      write_grp(8'h6B, 16'($urandom), 15);
      chk("R3 15-bit write ignored", 32'(g2_now), 32'(exp_g2));
      write_grp(8'h6B, 16'($urandom), 17);
      chk("R3 17-bit write ignored", 32'(g2_now), 32'(exp_g2));

      o0 = oe_cnt;
      write_grp(8'h6D, 16'hFFFF, 16);
      chk("R2 stray address group one", 32'(g1_now), 32'(exp_g1));
      chk("R2 stray address group two", 32'(g2_now), 32'(exp_g2));
      chk("R2 stray address no data out", 32'(oe_cnt - o0), 32'd0);

      v = exp_g1; v[5] = 1'b1;
      set_g1(v);
      chk("R4 hold set no restart", 32'(rs_cnt), 32'd0);
      chk("R4 hold bit visible", 32'(cfg_sync_hold), 32'd1);
      v[5] = 1'b0;
      set_g1(v);
      chk("R4 hold release one restart", 32'(rs_cnt), 32'd1);
      set_g1(v);
      chk("R4 repeat clear no restart", 32'(rs_cnt), 32'd1);

      v = 16'($urandom) & 16'h3FFF; v[5] = 1'b0; v[9:7] = 3'($urandom_range(0, 5));
      set_g1(v);
      push_rand(10);
      p0 = pop_cnt; o0 = oe_cnt;
      idle_hi = 1'b0;
      read_bits(4 * 32, "R5 R6 R7 R9 stream idle low");
      chk("R5 data out enabled in read", 32'(oe_cnt > o0), 32'd1);
      v[9:7] = 3'($urandom_range(0, 5));
      set_g1(v);
      idle_hi = 1'b1;
      read_bits(3 * 32, "R10 R6 R7 stream idle high");
      chk("R9 seven releases", 32'(pop_cnt - p0), 32'd7);

      p0 = pop_cnt;
      idle_hi = 1'b0;
      read_bits(20, "R9 partial");
      chk("R9 cut-off read keeps entry", 32'(pop_cnt - p0), 32'd0);
      read_bits(32, "R9 re-read same entry");
      chk("R9 full frame releases", 32'(pop_cnt - p0), 32'd1);
      idle_hi = 1'b1;
      read_bits(31, "R9 partial 31");
      chk("R9 release on 31st clock", 32'(pop_cnt - p0), 32'd2);
      read_bits(32, "R9 last entry");
      p0 = pop_cnt;
      read_bits(2 * 32, "R8 empty frames zero");
      chk("R8 empty read releases none", 32'(pop_cnt - p0), 32'd0);

      v[9:7] = 3'($urandom_range(0, 5));
      set_g1(v);
      push_rand(24);
      p0 = pop_cnt;
      idle_hi = 1'($urandom);
      read_bits(25 * 32, "R7 R8 R9 full buffer drain");
      chk("R9 full drain releases", 32'(pop_cnt - p0), 32'd24);

      finish_run();
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

endmodule